// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous host read and write an external asynchronous static RAM of 524,288 bytes (19-bit address, 8-bit data). The host issues one access at a time through a request/ready handshake. The controller registers the address and write data when it accepts the request. It then sequences the active-low chip-select, write-strobe and output-enable lines. It holds each phase for a whole number of clock cycles, derived from nanosecond timing parameters and a clock-period parameter.

All memory-side outputs are registered. The 8-bit data bus is split into an outgoing value, a drive-enable and an incoming value, so the pad ring can build the tristate buffer. The controller raises the drive-enable only when the memory cannot be driving the bus. A read always ends with a bus-turnaround wait. Between accesses the memory is deselected so that it drops into standby.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `host_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `host_rvalid` is 0.
- R2: Whenever `host_ready` is 1 the memory is deselected: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0.
- R3: A request is accepted on a rising edge where `host_req` and `host_ready` are both 1. `host_ready` is 0 from that edge until the access finishes. `mem_addr` stays constant while `mem_ce_n` is low.
- R4: For a write (`host_we`=1), `mem_we_n` is low for exactly PW cycles, where PW is the largest of ceil(T_PWE/CLK), ceil(T_SD/CLK) and ceil(T_AW/CLK). This is 10 cycles at the defaults. While `mem_we_n` is low, `mem_dq_oe` is 1, `mem_ce_n` is 0 and `mem_dq_o` holds the accepted write data.
- R5: Every access keeps `mem_ce_n` low for at least ceil(T_WC/CLK) cycles for a write and ceil(T_RC/CLK) cycles for a read. Both are 14 cycles at the defaults.
- R6: For a read, `mem_oe_n` and `mem_ce_n` are low and `mem_we_n` is high. `mem_dq_i` is sampled on the RD-th rising edge after acceptance, where RD is the largest of the ceil values of T_RC, T_AA, T_ACE and T_DOE (14 at the defaults). `host_rdata` carries that sample while `host_rvalid` pulses high for one cycle, in the cycle after that edge.
- R7: `mem_dq_oe` is 0 whenever `mem_oe_n` is low. It stays 0 for at least ceil(T_HZ/CLK) cycles (5 at the defaults) after `mem_oe_n` rises.
- R8: A read of an address returns the last byte written there, including at addresses 0 and 19'h7FFFF.
- R9: `mem_oe_n` and `mem_we_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller can accept a request |
| host_rdata | output | 8 | Read data |
| host_rvalid | output | 1 | One-cycle strobe marking `host_rdata` valid |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The hardest cases to reach are a read whose capture edge sits exactly at the access-time limit, and a write that follows a read as early as the handshake allows. The memory model in the bench returns a poison byte until the model has seen chip select low for 14 cycles and output enable low for 7. A capture one edge early therefore shows up as wrong data. The driver presents the next write on the first cycle `host_ready` returns, so the gap between the end of the read and the first bus drive is as short as the design permits. The monitor measures that gap and the strobe width in cycles.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [3:0] {
    IDLE, RD_SETUP, RD_WAIT, RD_CAPTURE,
    WR_SETUP, WR_PULSE, WR_HOLD, TURNAROUND
  } asram_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_cyc_timer.sv
module asram_cyc_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= dq_i;
    end
  end

  // R6: strobe is a single-cycle pulse
  a_r6_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 4,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_ACE_NS  = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_AW_NS   = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_HZ_NS   = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // Cycle counts derived from the nanosecond limits
  localparam int RD_CYC = max2(3, max2(max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                       max2(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS))));
  localparam int PW_CYC = max2(1, max2(ns_to_cyc(T_PWE_NS, CLK_NS),
                                       max2(ns_to_cyc(T_SD_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS))));
  localparam int WC_CYC = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int HOLD_CYC = max2(1, WC_CYC - 1 - PW_CYC);
  localparam int HZ_CYC = max2(1, ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int MAX_CYC = max2(max2(RD_CYC, PW_CYC), max2(HOLD_CYC, HZ_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1) + 1;

  asram_state_e     st;
  logic             t_load, t_done, cap;
  logic [CNT_W-1:0] t_val;

  // Timer loads on entry to each counted state
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    case (st)
      RD_SETUP:   begin t_load = 1'b1; t_val = CNT_W'(RD_CYC - 3);   end
      RD_CAPTURE: begin t_load = 1'b1; t_val = CNT_W'(HZ_CYC - 1);   end
      WR_SETUP:   begin t_load = 1'b1; t_val = CNT_W'(PW_CYC - 1);   end
      WR_PULSE:   begin t_load = t_done; t_val = CNT_W'(HOLD_CYC - 1); end
      default: ;
    endcase
  end

  asram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  assign cap = (st == RD_CAPTURE);

  asram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .capture(cap), .dq_i(mem_dq_i),
    .rdata(host_rdata), .rvalid(host_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      host_ready <= 1'b1;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_o   <= '0;
    end else begin
      case (st)
        IDLE: if (host_req) begin
          host_ready <= 1'b0;
          mem_addr   <= host_addr;
          mem_ce_n   <= 1'b0;
          if (host_we) begin
            mem_dq_o  <= host_wdata;
            mem_dq_oe <= 1'b1;
            st        <= WR_SETUP;
          end else begin
            mem_oe_n  <= 1'b0;
            st        <= RD_SETUP;
          end
        end
        RD_SETUP:   st <= RD_WAIT;
        RD_WAIT:    if (t_done) st <= RD_CAPTURE;
        RD_CAPTURE: begin
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          st       <= TURNAROUND;
        end
        TURNAROUND: if (t_done) begin
          host_ready <= 1'b1;
          st         <= IDLE;
        end
        WR_SETUP: begin
          mem_we_n <= 1'b0;
          st       <= WR_PULSE;
        end
        WR_PULSE: if (t_done) begin
          mem_we_n <= 1'b1;
          st       <= WR_HOLD;
        end
        WR_HOLD: if (t_done) begin
          mem_ce_n   <= 1'b1;
          mem_dq_oe  <= 1'b0;
          host_ready <= 1'b1;
          st         <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R2: idle means deselected and bus released
  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  // R3: address frozen while selected
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  // R4: write strobe only while selected and driving
  a_r4_we_with_drive: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe && $stable(mem_dq_o)));
  // R7: never drive while memory output is enabled
  a_r7_no_contention: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);
  // R9: output enable and write strobe exclusive
  a_r9_oe_we_excl: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;
  localparam int RD_EXP = 14;
  localparam int PW_EXP = 10;
  localparam int CE_MIN = 14;
  localparam int HZ_EXP = 5;
  localparam int DOE_EXP = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [18:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready, host_rvalid;
  logic [7:0]  host_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hEE;

  always #2 clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model and reference memory
  logic [7:0] mem_arr [int];
  logic [7:0] ref_arr [int];
  logic [7:0] exp_q [$];
  int acc_q [$];

  int ce_run = 0, we_run = 0, oe_run = 0, oe_hi = 99;
  logic prev_oe_n = 1, prev_dqoe = 0, prev_rv = 0, prev_ready = 1;
  logic [7:0] wr_hold;

  always @(negedge clk) if (!rst) begin
    // R7: contention and turnaround
    if (mem_dq_oe && !mem_oe_n) check(0, "R7 drive with oe", 1, 0);
    if (mem_dq_oe && !prev_dqoe) check(oe_hi >= HZ_EXP, "R7 turnaround", oe_hi, HZ_EXP);
    // R9
    if (!mem_oe_n && !mem_we_n) check(0, "R9 oe/we overlap", 1, 0);
    // R2 at each return of ready
    if (host_ready && !prev_ready)
      check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R2 idle deselect",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    // R5: chip-select length
    if (mem_ce_n && ce_run > 0) begin
      check(ce_run >= CE_MIN, "R5 ce low length", ce_run, CE_MIN);
      ce_run = 0;
    end else if (!mem_ce_n) ce_run++;
    // R4: write strobe width and data
    if (!mem_we_n) begin
      if (we_run == 0) wr_hold = mem_dq_o;
      if (!mem_dq_oe || mem_ce_n || mem_dq_o != wr_hold)
        check(0, "R4 data during strobe", mem_dq_o, wr_hold);
      we_run++;
      mem_arr[int'(mem_addr)] = mem_dq_o;
    end else if (we_run > 0) begin
      check(we_run == PW_EXP, "R4 strobe width", we_run, PW_EXP);
      we_run = 0;
    end
    if (!mem_oe_n) begin oe_run++; oe_hi = 0; end
    else begin oe_run = 0; if (oe_hi < 99) oe_hi++; end
    // Memory read port: poison until access time met
    if (!mem_ce_n && !mem_oe_n && mem_we_n && ce_run >= RD_EXP && oe_run >= DOE_EXP)
      mem_dq_i = mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : 8'h00;
    else mem_dq_i = 8'hEE;
    // Scoreboard monitor: R6 / R8
    if (host_rvalid) begin
      if (prev_rv) check(0, "R6 rvalid pulse", 1, 0);
      if (exp_q.size() == 0) check(0, "R6 unexpected rvalid", 1, 0);
      else begin
        logic [7:0] e;
        int a;
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        check(cyc - a == RD_EXP, "R6 capture edge", cyc - a, RD_EXP);
        check(host_rdata == e, "R8 read data", host_rdata, e);
      end
    end
    prev_rv = host_rvalid;
    prev_dqoe = mem_dq_oe;
    prev_oe_n = mem_oe_n;
    prev_ready = host_ready;
  end

  task automatic issue(input bit we, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 0;
    check(!host_ready, "R3 ready low after accept", host_ready, 0);
    if (we) ref_arr[int'(a)] = d;
    else begin
      exp_q.push_back(ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : 8'h00);
      acc_q.push_back(cyc);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(host_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_rvalid,
          "R1 reset state", {host_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);
    rst = 0;
    @(negedge clk);
    check(host_ready && mem_ce_n && !mem_dq_oe, "R1 after reset", host_ready, 1);
    issue(1, 19'h00000, 8'h11);
    issue(1, 19'h7FFFF, 8'h5A);
    issue(1, 19'h12345, 8'hC3);
    issue(0, 19'h00000, 8'h00);
    issue(0, 19'h7FFFF, 8'h00);
    issue(1, 19'h00042, 8'h3C);  // write directly after read
    issue(0, 19'h12345, 8'h00);
    issue(0, 19'h00042, 8'h00);
    issue(1, 19'h12345, 8'h96);  // overwrite
    issue(0, 19'h12345, 8'h00);
    issue(1, 19'h40000, 8'hFF);
    issue(0, 19'h40000, 8'h00);
    issue(0, 19'h00000, 8'h00);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule